// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a narrow window onto a wide internal register file. The host sees only a few directly addressed 16-bit registers: a status word, a revision word, an indirect address word and four data words. Each internal entry is 64 bits wide. The host reaches an entry through an address word that names the functional block type, the instance and the parameter of that entry.

Software first stages up to four 16-bit words in the data registers. It then writes the address register, and that write is what starts the internal transaction. Bit 7 of the address word picks the direction. A write transaction moves all four staged words into the selected entry. A read transaction copies one 16-bit word of the entry, chosen by the read-back index in address bits 1:0, into data register 0. A wide entry is therefore read one word per transaction. The status register shows a busy flag for the fixed duration of each transaction.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the status, address and data registers read 0, and the revision offset reads the `REV_VALUE` parameter.
- R2: Host writes to the data registers start no transaction: status bit 0 stays 0, and the internal entries keep their previous contents (entries reset to 0).
- R3: A write to the address register while idle sets status bit 0 from the next cycle onward. The bit stays 1 for exactly `LATENCY` consecutive cycles.
- R4: Address bit 7 = 0 makes a write transaction. It stores data registers 3..2..1..0, as they were on the cycle of the address write, as bits 63:48..47:32..31:16..15:0 of the selected entry. Data writes made while the transaction is busy do not change what is stored.
- R5: Address bit 7 = 1 makes a read transaction. When it completes, data register 0 receives word `addr[1:0]` (bits 16*k+15:16*k) of the selected entry, and data registers 1 to 3 keep their values.
- R6: Address-register writes while busy are ignored. The address readback keeps the accepted value, and no second transaction starts.
- R7: Host reads return data on the cycle after the read strobe. Byte offsets: 0x10 gives status (bit 0 = busy, bits 15:1 = 0), 0x20 gives the revision, 0x30 gives the last accepted address, and 0x40, 0x50, 0x60 and 0x70 give data registers 0 to 3. Any other offset, including one with a non-zero low nibble, reads 0 and ignores writes.
- R8: When a read transaction completes on the same edge as a host write to data register 0, the read-back word is what gets stored.
- R9: The entry index is {addr[13:12], addr[9:8], addr[3:2]} (type, instance, parameter; the low bits of each field). Address bits 15:14, 11:10 and 6:4 do not change which entry is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_addr | input | 8 | Host byte offset of the register accessed |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered, valid the cycle after the read strobe |

## Verification
The hardest case to reach is the completion edge of a read transaction that coincides with a host write to data register 0. Reaching it needs the data write placed exactly `LATENCY` cycles after the address write. The stimulus counts negative edges from the address write to land on that edge. Other cases need data writes and address writes made while busy, and these are driven while the status poll still reports 1. Aliased address words that differ only in the ignored bits are written and read to show that they select the same entry.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_WORDS = 4;
    localparam int DIR_BIT   = 7;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] wide_t;

    // Host register offsets, upper nibble of the byte offset
    localparam logic [3:0] OFS_STATUS = 4'h1;
    localparam logic [3:0] OFS_REV    = 4'h2;
    localparam logic [3:0] OFS_ADDR   = 4'h3;
    localparam logic [3:0] OFS_DATA0  = 4'h4;

    typedef struct packed {
        logic                 status;
        logic                 rev;
        logic                 addr;
        logic [NUM_WORDS-1:0] data;
    } host_sel_t;

    function automatic logic addr_is_read(word_t a);
        return a[DIR_BIT];
    endfunction

    function automatic logic [1:0] addr_word(word_t a);
        return a[1:0];
    endfunction

    function automatic logic [1:0] addr_param(word_t a);
        return a[3:2];
    endfunction

endpackage

// File: rtl/ibr_host_decode.sv
module ibr_host_decode
    import ibr_pkg::*;
(
    input  logic [7:0] host_addr,
    output host_sel_t  sel_o
);

    logic aligned;
    assign aligned = (host_addr[3:0] == 4'h0);

    always_comb begin
        sel_o        = '0;
        sel_o.status = aligned && (host_addr[7:4] == OFS_STATUS);
        sel_o.rev    = aligned && (host_addr[7:4] == OFS_REV);
        sel_o.addr   = aligned && (host_addr[7:4] == OFS_ADDR);
        for (int i = 0; i < NUM_WORDS; i++) begin
            sel_o.data[i] = aligned && (host_addr[7:4] == 4'(OFS_DATA0 + 4'(i)));
        end
    end

endmodule

// File: rtl/ibr_txn_seq.sv
module ibr_txn_seq #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic start_read_i,
    output logic busy_o,
    output logic done_o,
    output logic done_read_o
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             rd;
    } seq_t;

    seq_t st_d, st_q;
    logic last;

    assign last = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(LATENCY - 1);
            st_d.rd   = start_read_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.busy;
    assign done_o      = last;
    assign done_read_o = last && st_q.rd;

endmodule

// File: rtl/ibr_regfile.sv
module ibr_regfile
    import ibr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  wide_t            wdata_i,
    input  logic [1:0]       word_i,
    output word_t            rword_o
);

    localparam int DEPTH = 1 << IDX_W;

    wide_t mem_d [DEPTH];
    wide_t mem_q [DEPTH];
    wide_t entry;
    word_t words [NUM_WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign entry = mem_q[idx_i];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        assign words[g] = entry[g];
    end

    assign rword_o = words[word_i];

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int          LATENCY    = 4,
    parameter int          TYPE_IDX_W = 2,
    parameter int          INST_IDX_W = 2,
    parameter logic [15:0] REV_VALUE  = 16'h0123
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata
);

    localparam int IDX_W = TYPE_IDX_W + INST_IDX_W + 2;

    typedef struct packed {
        word_t addr;
        wide_t data;
        wide_t snap;
        word_t rdata;
    } bridge_t;

    bridge_t    st_d, st_q;
    host_sel_t  sel;
    logic       busy;
    logic       done;
    logic       done_read;
    logic       start;
    word_t      rf_rdata;
    logic [IDX_W-1:0] idx;
    word_t      addr_reg;
    wide_t      data_regs;

    ibr_host_decode u_dec (
        .host_addr (host_addr),
        .sel_o     (sel)
    );

    assign start = host_wr && sel.addr && !busy;

    ibr_txn_seq #(.LATENCY(LATENCY)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .start_read_i (addr_is_read(host_wdata)),
        .busy_o       (busy),
        .done_o       (done),
        .done_read_o  (done_read)
    );

    // Entry index: low bits of type, instance and parameter fields
    assign idx = {st_q.addr[12 +: TYPE_IDX_W],
                  st_q.addr[8 +: INST_IDX_W],
                  addr_param(st_q.addr)};

    ibr_regfile #(.IDX_W(IDX_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (done && !done_read),
        .idx_i   (idx),
        .wdata_i (st_q.snap),
        .word_i  (addr_word(st_q.addr)),
        .rword_o (rf_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (host_wr) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (sel.data[i]) begin
                    st_d.data[i] = host_wdata;
                end
            end
        end
        if (start) begin
            st_d.addr = host_wdata;
            st_d.snap = st_q.data;
        end
        if (done_read) begin
            st_d.data[0] = rf_rdata;
        end
        if (host_rd) begin
            st_d.rdata = '0;
            if (sel.status) st_d.rdata = {15'b0, busy};
            if (sel.rev)    st_d.rdata = REV_VALUE;
            if (sel.addr)   st_d.rdata = st_q.addr;
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (sel.data[i]) st_d.rdata = st_q.data[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rdata;
    assign addr_reg   = st_q.addr;
    assign data_regs  = st_q.data;

endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk
    import ibr_pkg::*;
#(
    parameter int          LATENCY   = 4,
    parameter logic [15:0] REV_VALUE = 16'h0123
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_rd,
    input logic [7:0]  host_addr,
    input logic [15:0] host_rdata,
    input logic        busy,
    input logic        done_read,
    input word_t       rf_rdata,
    input word_t       addr_reg,
    input wide_t       data_regs
);

    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 16'd1;
        end else begin
            run_q <= '0;
        end
    end

    // R3: an accepted address write raises busy on the next cycle
    assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h30 && !busy) |=> busy);

    // R3: busy lasts exactly LATENCY cycles
    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 16'(LATENCY)));

    // R6: address register holds while busy
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && host_addr == 8'h30) |=> $stable(addr_reg));

    // R5: upper data registers untouched by a read completion
    assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_read && !(host_wr && (host_addr == 8'h50 || host_addr == 8'h60 ||
                                    host_addr == 8'h70)))
        |=> $stable(data_regs[3:1]));

    // R8: read-back word lands in data register 0
    assert_rb_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_read |=> (data_regs[0] == $past(rf_rdata)));

    // R7: status upper bits read 0
    assert_status_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 8'h10) |=> (host_rdata[15:1] == 15'b0));

    // R7: revision offset returns the parameter
    assert_rev_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 8'h20) |=> (host_rdata == REV_VALUE));

endmodule

bind ibr_bridge ibr_bridge_chk #(.LATENCY(LATENCY), .REV_VALUE(REV_VALUE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .busy       (busy),
    .done_read  (done_read),
    .rf_rdata   (rf_rdata),
    .addr_reg   (addr_reg),
    .data_regs  (data_regs)
);

// File: tb/test_ibr_bridge.sv
`timescale 1ns/1ps
module test_ibr_bridge;

    localparam int          LAT = 4;
    localparam logic [15:0] REV = 16'h0123;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ibr_bridge #(.LATENCY(LAT), .REV_VALUE(REV)) i_ibr_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_mem [64];
    logic [15:0] m_data [4];
    logic [15:0] m_snap [4];
    logic [15:0] m_addr, m_rdata;
    bit          m_busy, m_isrd;
    int          m_cnt;

    function automatic int m_idx(logic [15:0] a);
        return ((int'(a) >> 12) & 3) * 16 + ((int'(a) >> 8) & 3) * 4 + ((int'(a) >> 2) & 3);
    endfunction

    function automatic logic [15:0] m_read(logic [7:0] a);
        if (a == 8'h10) return {15'b0, m_busy};
        if (a == 8'h20) return REV;
        if (a == 8'h30) return m_addr;
        if (a == 8'h40) return m_data[0];
        if (a == 8'h50) return m_data[1];
        if (a == 8'h60) return m_data[2];
        if (a == 8'h70) return m_data[3];
        return 16'h0;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        for (int i = 0; i < 4; i++) begin m_data[i] = '0; m_snap[i] = '0; end
        m_addr = '0; m_rdata = '0; m_busy = 0; m_isrd = 0; m_cnt = 0;
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            bit          was_busy;
            bit          fin_rd;
            logic [15:0] rb;
            logic [15:0] pre [4];
            was_busy = m_busy;
            fin_rd   = 0;
            rb       = '0;
            for (int i = 0; i < 4; i++) pre[i] = m_data[i];
            if (host_rd) m_rdata = m_read(host_addr);
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy = 0;
                    if (m_isrd) begin
                        fin_rd = 1;
                        rb = m_mem[m_idx(m_addr)][16*int'(m_addr[1:0]) +: 16];
                    end else begin
                        m_mem[m_idx(m_addr)] = {m_snap[3], m_snap[2], m_snap[1], m_snap[0]};
                    end
                end else begin
                    m_cnt--;
                end
            end
            if (host_wr) begin
                for (int i = 0; i < 4; i++)
                    if (host_addr == 8'(8'h40 + 16 * i)) m_data[i] = host_wdata;
                if (host_addr == 8'h30 && !was_busy) begin
                    m_addr = host_wdata;
                    for (int i = 0; i < 4; i++) m_snap[i] = pre[i];
                    m_busy = 1;
                    m_cnt  = LAT - 1;
                    m_isrd = host_wdata[7];
                end
            end
            if (fin_rd) m_data[0] = rb;
        end
    end

    // Per-clock comparison of the host read path against the model (R7)
    always @(negedge clk) begin
        if (rst_n) chk("R7 model", host_rdata, m_rdata);
    end

    // ---------------- stimulus tasks (called at a negedge) ----------------
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        v = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic wait_idle(output int ones);
        logic [15:0] s;
        ones = 0;
        for (int n = 0; n < 50; n++) begin
            rd(8'h10, s);
            if (s[0] == 1'b0) break;
            ones++;
        end
    endtask

    task automatic read_entry(input logic [15:0] a, output logic [15:0] v);
        int o;
        wr(8'h30, a);
        wait_idle(o);
        rd(8'h40, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h10, v); chk("R1 status", v, 16'h0);
        rd(8'h20, v); chk("R1 rev", v, REV);
        rd(8'h30, v); chk("R1 addr", v, 16'h0);
        rd(8'h40, v); chk("R1 data0", v, 16'h0);
        rd(8'h70, v); chk("R1 data3", v, 16'h0);

        // R2: staging data starts nothing
        wr(8'h40, 16'h1111); wr(8'h50, 16'h2222);
        wr(8'h60, 16'h3333); wr(8'h70, 16'h4444);
        repeat (6) @(negedge clk);
        rd(8'h10, v); chk("R2 status idle", v, 16'h0);
        read_entry(16'h2186, v); chk("R2 entry untouched", v, 16'h0);
        rd(8'h60, v); chk("R7 data2 readback", v, 16'h3333);

        // R3/R4: write transaction, data changed while busy
        wr(8'h40, 16'h1111);
        wr(8'h30, 16'h2104);
        wr(8'h40, 16'hFFFF);
        wait_idle(o);
        chk("R3 busy length", 16'(o + 1), 16'(LAT));
        for (int w = 0; w < 4; w++) begin
            read_entry(16'h2184 | 16'(w), v);
            chk("R4 stored word", v, 16'h1111 * 16'(w + 1));
        end
        // R5: upper data registers kept after read transactions
        rd(8'h50, v); chk("R5 data1 kept", v, 16'h2222);
        rd(8'h70, v); chk("R5 data3 kept", v, 16'h4444);

        // R3: busy count from the address write itself
        wr(8'h30, 16'h2184);
        wait_idle(o);
        chk("R3 busy cycles", 16'(o), 16'(LAT));

        // R6: address write while busy is ignored
        wr(8'h40, 16'h5555); wr(8'h50, 16'h6666);
        wr(8'h30, 16'h3108);
        wr(8'h30, 16'h1204);
        wait_idle(o);
        rd(8'h30, v); chk("R6 addr kept", v, 16'h3108);
        rd(8'h10, v); chk("R6 no second txn", v, 16'h0);
        read_entry(16'h1284, v); chk("R6 other entry untouched", v, 16'h0);
        read_entry(16'h3189, v); chk("R4 new entry word1", v, 16'h6666);

        // R8: completion collides with a host write to data0
        wr(8'h30, 16'h2187);
        repeat (LAT - 1) @(negedge clk);
        wr(8'h40, 16'hBEEF);
        wait_idle(o);
        rd(8'h40, v); chk("R8 readback wins", v, 16'h4444);

        // R9: ignored address bits alias to one entry
        wr(8'h40, 16'hA0A0); wr(8'h50, 16'hA1A1);
        wr(8'h30, 16'hD608);
        wait_idle(o);
        read_entry(16'h12F9, v); chk("R9 alias word1", v, 16'hA1A1);
        read_entry(16'h52CB, v); chk("R9 alias word3", v, 16'h4444);

        // R7: unmapped and misaligned offsets
        rd(8'h00, v); chk("R7 unmapped 0x00", v, 16'h0);
        rd(8'h80, v); chk("R7 unmapped 0x80", v, 16'h0);
        rd(8'h21, v); chk("R7 misaligned read", v, 16'h0);
        rd(8'h40, v);
        wr(8'h41, 16'h7777);
        rd(8'h40, o == 0 ? v : v);
        chk("R7 misaligned write ignored", v, 16'h4444);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule